// File: doc/BRIEF.md
# Nibble-Protected Byte FIFO

A synchronous first-in first-out buffer for 8-bit serial-link characters whose storage can carry error correction. With protection enabled, every byte is split into its low and high nibble on the way in. Each nibble becomes its own 7-bit single-error-correcting Hamming codeword, so one entry is 14 bits wide. On the way out each codeword is checked and repaired on its own, so one flipped bit per nibble is removed before the byte leaves the block. With protection disabled, entries are the plain 8 bits.

The producer raises `push` with a byte and the consumer raises `pop`. A pop that is accepted returns its byte one clock later, qualified by `rd_valid`. `full`, `empty` and `level` come from a single occupancy counter. A test-only XOR mask is applied to the encoded word as it is written, so any chosen bits of a stored entry can be corrupted to exercise the correction path. Depth is a parameter from 2 to 1024 entries.

Top module: `ecc_fifo`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `empty` is 1, `full` is 0, `level` is 0 and `rd_valid` is 0.
- R2: Bytes leave in the order they were accepted. A pop accepted at clock edge k sets `rd_valid` after edge k, and `rd_data` holds that byte until the next accepted pop.
- R3: A push while `full` is 1 is dropped, even when a pop happens in the same cycle. It does not change `level` and does not overwrite any stored byte.
- R4: A pop while `empty` is 1 is dropped. `rd_valid` is 0 after that edge and `level` stays 0.
- R5: `level` rises by one on an accepted push alone, falls by one on an accepted pop alone, and is unchanged when both or neither are accepted. It never exceeds DEPTH.
- R6: `full` is 1 exactly when `level` equals DEPTH, and `empty` is 1 exactly when `level` is 0.
- R7: With protection on, stored bits [6:0] hold the low nibble and bits [13:7] hold the high nibble. Inside each 7-bit group, bit indices 0 to 6 hold p1, p2, d1, p3, d2, d3, d4, where d1 is the nibble's least significant bit. The check bits are p1 = d1^d2^d4, p2 = d1^d3^d4 and p3 = d2^d3^d4. `fault_mask` is XORed onto these 14 bits when the byte is pushed. For example, pushing 0xC3 with mask 0x0003 reads back 0xC2, and mask 0x0180 reads back 0xD3.
- R8: A single flipped bit at any of the 14 stored positions is corrected, and `rd_data` equals the pushed byte.
- R9: One flipped bit in each nibble's codeword at the same time is corrected in both.
- R10: `corrected` is 1 on a read cycle exactly when the syndrome of at least one nibble is nonzero. It is 0 for an entry stored with no flipped bits.
- R11: `corrected` is never 1 while `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write request |
| push_data | input | 8 | Byte to store |
| fault_mask | input | 14 | Test XOR mask applied to the encoded word on write |
| pop | input | 1 | Read request |
| rd_valid | output | 1 | `rd_data` holds a byte popped at the previous edge |
| rd_data | output | 8 | Decoded and corrected byte |
| corrected | output | 1 | A nonzero syndrome was seen in the current read |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| level | output | $clog2(DEPTH+1) | Number of stored entries |

## Verification
The bench sweeps a single-bit fault across all 14 stored positions and then pairs one fault per nibble. A decoder that flipped the wrong position, or that shared one syndrome across both nibbles, would return a damaged byte. Two-bit faults inside one nibble land on a known data bit only when the bit order is exactly right, so a swapped check or data position shows up as a wrong byte. The bench also pushes into a full buffer, pops from an empty one, and issues push and pop together at both limits. A design that let a blocked push through would overwrite the oldest entry or push `level` past DEPTH, and one that accepted an empty pop would raise `rd_valid` with stale data.

// File: rtl/ecc_fifo_pkg.sv
package ecc_fifo_pkg;
   localparam int WORD_W    = 8;
   localparam int NIB_W     = 4;
   localparam int CW_W      = 7;
   localparam int NIBBLES   = WORD_W / NIB_W;
   localparam int CODE_W    = NIBBLES * CW_W;
   localparam int MAX_DEPTH = 1024;

   typedef logic [NIB_W-1:0] nib_t;
   typedef logic [CW_W-1:0]  cw_t;
endpackage

// File: rtl/ecc_nib_enc.sv
module ecc_nib_enc
   import ecc_fifo_pkg::*;
(
   input  nib_t nib,
   output cw_t  cw
);
   // index: 0=p1 1=p2 2=d1 3=p3 4=d2 5=d3 6=d4 (d1 = nib[0])
   assign cw[0] = nib[0] ^ nib[1] ^ nib[3];
   assign cw[1] = nib[0] ^ nib[2] ^ nib[3];
   assign cw[2] = nib[0];
   assign cw[3] = nib[1] ^ nib[2] ^ nib[3];
   assign cw[4] = nib[1];
   assign cw[5] = nib[2];
   assign cw[6] = nib[3];
endmodule

// File: rtl/ecc_nib_dec.sv
module ecc_nib_dec
   import ecc_fifo_pkg::*;
(
   input  cw_t  cw,
   output nib_t nib,
   output logic err
);
   logic [2:0] syn;
   cw_t        flip;
   cw_t        fixed;

   // syndrome value = 1-based position of the flipped bit
   assign syn[0] = cw[0] ^ cw[2] ^ cw[4] ^ cw[6];
   assign syn[1] = cw[1] ^ cw[2] ^ cw[5] ^ cw[6];
   assign syn[2] = cw[3] ^ cw[4] ^ cw[5] ^ cw[6];

   always_comb begin
      for (int i = 0; i < CW_W; i++) begin
         flip[i] = (syn == 3'(i + 1));
      end
   end

   assign fixed = cw ^ flip;
   assign nib   = {fixed[6], fixed[5], fixed[4], fixed[2]};
   assign err   = |syn;
endmodule

// File: rtl/ecc_fifo_ptr.sv
module ecc_fifo_ptr #(
   parameter int DEPTH = 16,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic          pop,
   output logic          do_push,
   output logic          do_pop,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == LAST) ? '0 : p + AW'(1);
   endfunction

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= bump(wr_ptr);
         if (do_pop)  rd_ptr <= bump(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   level <= level + LW'(1);
            2'b01:   level <= level - LW'(1);
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/ecc_fifo.sv
module ecc_fifo
   import ecc_fifo_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter bit ECC_EN = 1'b1,
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [WORD_W-1:0] push_data,
   input  logic [CODE_W-1:0] fault_mask,
   input  logic              pop,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_data,
   output logic              corrected,
   output logic              full,
   output logic              empty,
   output logic [LW-1:0]     level
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int SW = ECC_EN ? CODE_W : WORD_W;

   if (DEPTH < 2 || DEPTH > MAX_DEPTH) begin : g_bad_depth
      $error("ecc_fifo: DEPTH must lie in 2..%0d", MAX_DEPTH);
   end

   logic          do_push, do_pop;
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [SW-1:0] enc_word, store_word, rd_q;
   logic [SW-1:0] mem [DEPTH];

   ecc_fifo_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk     (clk),
      .rst     (rst),
      .push    (push),
      .pop     (pop),
      .do_push (do_push),
      .do_pop  (do_pop),
      .wr_ptr  (wr_ptr),
      .rd_ptr  (rd_ptr),
      .level   (level),
      .full    (full),
      .empty   (empty)
   );

   if (ECC_EN) begin : g_ecc
      logic [NIBBLES-1:0] nib_err;
      for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
         ecc_nib_enc u_enc (
            .nib (push_data[g*NIB_W +: NIB_W]),
            .cw  (enc_word[g*CW_W +: CW_W])
         );
         ecc_nib_dec u_dec (
            .cw  (rd_q[g*CW_W +: CW_W]),
            .nib (rd_data[g*NIB_W +: NIB_W]),
            .err (nib_err[g])
         );
      end
      assign corrected = rd_valid && (|nib_err);
   end else begin : g_plain
      assign enc_word  = push_data;
      assign rd_data   = rd_q;
      assign corrected = 1'b0;
   end

   assign store_word = enc_word ^ fault_mask[SW-1:0];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= store_word;
   end

   always_ff @(posedge clk) begin
      if (do_pop) rd_q <= mem[rd_ptr];
   end

   always_ff @(posedge clk) begin
      if (rst) rd_valid <= 1'b0;
      else     rd_valid <= do_pop;
   end
endmodule

// File: rtl/ecc_fifo_chk.sv
module ecc_fifo_chk #(
   parameter int DEPTH = 16,
   localparam int LW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst,
   input logic          push,
   input logic          pop,
   input logic          rd_valid,
   input logic          corrected,
   input logic          full,
   input logic          empty,
   input logic [LW-1:0] level
);
   a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(full && empty));

   a_r5_level_bound: assert property (@(posedge clk) disable iff (rst)
      level <= LW'(DEPTH));

   a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
      (!push && !pop) |=> $stable(level));

   a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
      (full && push && !pop) |=> (full && $stable(level)));

   a_r4_empty_pop_dropped: assert property (@(posedge clk) disable iff (rst)
      (empty && pop) |=> !rd_valid);

   a_r2_pop_gives_valid: assert property (@(posedge clk) disable iff (rst)
      (pop && !empty) |=> rd_valid);

   a_r11_corr_needs_valid: assert property (@(posedge clk) disable iff (rst)
      corrected |-> rd_valid);
endmodule

bind ecc_fifo ecc_fifo_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .push      (push),
   .pop       (pop),
   .rd_valid  (rd_valid),
   .corrected (corrected),
   .full      (full),
   .empty     (empty),
   .level     (level)
);

// File: tb/ecc_fifo_tb.sv
`timescale 1ns/1ps
module ecc_fifo_tb;
   localparam int DEPTH = 16;
   localparam int LW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          push = 1'b0, pop = 1'b0;
   logic [7:0]    push_data = '0;
   logic [13:0]   fault_mask = '0;
   logic          rd_valid, corrected, full, empty;
   logic [7:0]    rd_data;
   logic [LW-1:0] level;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ecc_fifo #(.DEPTH(DEPTH), .ECC_EN(1'b1)) u_dut (
      .clk(clk), .rst(rst), .push(push), .push_data(push_data),
      .fault_mask(fault_mask), .pop(pop), .rd_valid(rd_valid),
      .rd_data(rd_data), .corrected(corrected), .full(full),
      .empty(empty), .level(level)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // expected read result from the code's linearity: syndrome = xor of error positions
   task automatic expect_read(input logic [7:0] d, input logic [13:0] m,
                              output logic [7:0] r, output logic c);
      r = d;
      c = 1'b0;
      for (int g = 0; g < 2; g++) begin
         logic [6:0] e;
         int syn;
         e = m[g*7 +: 7];
         syn = 0;
         for (int i = 0; i < 7; i++) if (e[i]) syn = syn ^ (i + 1);
         if (syn != 0) begin
            e[syn-1] = ~e[syn-1];
            c = 1'b1;
         end
         r[g*4 +: 4] = d[g*4 +: 4] ^ {e[6], e[5], e[4], e[2]};
      end
   endtask

   // behavioural reference model
   logic [21:0] q[$];
   logic        m_valid = 1'b0, m_corr = 1'b0;
   logic [7:0]  m_data = '0;

   always @(posedge clk) begin
      if (rst) begin
         q.delete();
         m_valid = 1'b0;
      end else begin
         bit acc_push, acc_pop;
         acc_push = push && (q.size() < DEPTH);
         acc_pop  = pop && (q.size() > 0);
         m_valid  = acc_pop;
         if (acc_pop) begin
            logic [21:0] e;
            e = q.pop_front();
            expect_read(e[21:14], e[13:0], m_data, m_corr);
         end
         if (acc_push) q.push_back({push_data, fault_mask});
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         chk(level == LW'(q.size()), "R5 level", level, q.size());
         chk(full == (q.size() == DEPTH) && empty == (q.size() == 0),
             "R6 flags", {full, empty}, {q.size() == DEPTH, q.size() == 0});
         chk(rd_valid == m_valid, "R2 rd_valid", rd_valid, m_valid);
         if (m_valid) begin
            chk(rd_data == m_data, "R2/R8 rd_data", rd_data, m_data);
            chk(corrected == m_corr, "R10 corrected", corrected, m_corr);
         end else begin
            chk(!corrected, "R11 corrected without valid", corrected, 0);
         end
      end
   end

   task automatic step(input bit p, input bit r, input logic [7:0] d, input logic [13:0] m);
      push = p; pop = r; push_data = d; fault_mask = m;
      @(posedge clk);
      @(negedge clk);
      push = 1'b0; pop = 1'b0; fault_mask = '0;
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(empty && !full && level == 0 && !rd_valid, "R1 reset state",
          {empty, full, rd_valid}, 3'b100);
      rst = 1'b0;
      @(negedge clk);
      chk(empty && level == 0 && !rd_valid, "R1 after release", level, 0);

      // R2 / R10: clean order
      for (int i = 0; i < 5; i++) step(1, 0, 8'h30 + 8'(i), '0);
      for (int i = 0; i < 5; i++) begin
         step(0, 1, '0, '0);
         chk(rd_data == 8'h30 + 8'(i) && !corrected, "R10 clean read", rd_data, 8'h30 + i);
      end

      // R4: pop when empty
      step(0, 1, '0, '0);
      chk(!rd_valid && level == 0, "R4 empty pop", rd_valid, 0);
      // push+pop on empty: push only
      step(1, 1, 8'h5A, '0);
      chk(level == 1 && !rd_valid, "R4 push+pop on empty", level, 1);
      step(0, 1, '0, '0);

      // R3: overflow
      for (int i = 0; i < DEPTH; i++) step(1, 0, 8'(i * 7 + 1), '0);
      chk(full && level == LW'(DEPTH), "R6 full at depth", level, DEPTH);
      for (int i = 0; i < 3; i++) step(1, 0, 8'hEE, '0);
      chk(level == LW'(DEPTH), "R3 push on full dropped", level, DEPTH);
      step(1, 1, 8'hEE, '0);
      chk(level == LW'(DEPTH - 1) && rd_data == 8'h01, "R3 push+pop on full", rd_data, 1);
      // R5: push+pop together keeps level
      step(1, 1, 8'h77, '0);
      chk(level == LW'(DEPTH - 1), "R5 simultaneous push/pop", level, DEPTH - 1);
      while (!empty) step(0, 1, '0, '0);

      // R8: single-bit sweep
      for (int i = 0; i < 14; i++) begin
         step(1, 0, 8'hA5 ^ 8'(i * 17), 14'(1) << i);
         step(0, 1, '0, '0);
         chk(rd_data == (8'hA5 ^ 8'(i * 17)) && corrected, "R8 single flip",
             rd_data, 8'hA5 ^ 8'(i * 17));
      end

      // R9: one flip per nibble
      for (int i = 0; i < 7; i++) begin
         step(1, 0, 8'h3C ^ 8'(i), (14'(1) << i) | (14'(1) << (7 + ((i + 3) % 7))));
         step(0, 1, '0, '0);
         chk(rd_data == (8'h3C ^ 8'(i)) && corrected, "R9 flip in both nibbles",
             rd_data, 8'h3C ^ i);
      end

      // R7: bit layout via two-bit faults on p1,p2 (lands on d1)
      step(1, 0, 8'hC3, 14'h0003);
      step(0, 1, '0, '0);
      chk(rd_data == 8'hC2 && corrected, "R7 low nibble layout", rd_data, 8'hC2);
      step(1, 0, 8'hC3, 14'h0180);
      step(0, 1, '0, '0);
      chk(rd_data == 8'hD3 && corrected, "R7 high nibble layout", rd_data, 8'hD3);

      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule